// File: doc/BRIEF.md
# Bidirectional Ring Transfer Arbiter

This block decides which node of a twelve-node ring interconnect may start a data transfer, and on which ring it travels. The interconnect has four rings: rings 0 and 1 move data clockwise (node i to node i+1, wrapping 11 to 0), and rings 2 and 3 move data counterclockwise (node i to node i-1, wrapping 0 to 11). A node raises a request together with the destination node it wants to reach. The arbiter works out the shorter direction and checks which rings can take the transfer. A ring can take it if it is not already carrying its maximum number of packets and if none of the ring segments on the path is in use. The arbiter then answers the same cycle with a grant that names the ring, or with an error for a request that can never be served.

Every granted transfer is one fixed packet of eight 16-byte beats. The arbiter keeps the segments the packet reserved and its slot in the ring's concurrency count until the packet has finished, then releases both. One request is served per cycle. The nodes are served in round-robin order, so no node starves. A requester that cannot be placed yet is passed over, so nodes behind it are not blocked. The grant is combinational on the request, so a requester that sees its grant drops its request at the next edge.

Top module: `ring_bus_arbiter`

## Requirements
- R1: After reset no transfer is active, and the round-robin search starts at node 0. If nodes 3 and 11 request together first, node 3 is served before node 11.
- R2: A request whose destination equals its source, or whose destination is 12 or above, is answered with err_vld high and err_src set to the requester, and it is never granted. Such a request uses that cycle's single service slot.
- R3: Segment i of a clockwise ring is the link from node i to node i+1, and segment i of a counterclockwise ring is the link from node i to node i-1. The preferred direction is the one with fewer hops. When both are equal (six hops), clockwise is preferred. Inside a direction, the lower-numbered ring is tried first.
- R4: If neither ring in the preferred direction can accept the transfer, the first ring of the other direction that can accept it is granted, even though that path is longer.
- R5: A transfer reserves every segment from its source to its destination in its direction of travel. It is never granted on a ring where any of those segments is reserved.
- R6: A ring holds at most three active transfers. A fourth request is placed elsewhere or waits, even if its path does not overlap the others.
- R7: A transfer granted in cycle c holds its segments and its concurrency slot for the eight beat cycles c+1 to c+8. They are free again in cycle c+9.
- R8: At most one outcome (grant or error) is given per cycle, and only to a node whose request is raised. The search begins at the node after the last one served and wraps around.
- R9: A raised request that no ring can accept gets no outcome, and a placeable request behind it in round-robin order is served in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 12 | Per-node transfer request |
| req_dst | input | 48 | Per-node destination, 4 bits per node, node n at bits [4n+3:4n] |
| gnt_vld | output | 1 | A transfer is granted this cycle |
| gnt_src | output | 4 | Node receiving the grant |
| gnt_ring | output | 2 | Ring granted: 0,1 clockwise; 2,3 counterclockwise |
| err_vld | output | 1 | A request is rejected this cycle |
| err_src | output | 4 | Node receiving the rejection |

## Verification
The assertions check several things on every cycle. Grants and errors never coincide. Each outcome goes to a raised request. An error appears only for a self-addressed or out-of-range destination. An allocation never lands on a reserved segment or on a ring that is already at three transfers. A freshly reserved path is still occupied on the following cycle. Three behaviours need the bench scenarios, because they depend on sequences of cycles: the choice of direction and the fall-back to the longer direction, the round-robin order across cycles, and the exact release nine cycles after a grant.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;

  // Hops needed to go clockwise from src to dst on an n-node ring.
  function automatic int cw_hops(input int src, input int dst, input int n);
    return (dst - src + n) % n;
  endfunction

  // Clockwise wins when it is no longer than counterclockwise.
  function automatic logic prefer_cw(input int src, input int dst, input int n);
    int h;
    h = cw_hops(src, dst, n);
    return (h <= (n - h));
  endfunction

  // Whether segment seg lies on the path src->dst in the given direction.
  // Clockwise segment i links i to i+1; counterclockwise segment i links i to i-1.
  function automatic logic seg_on_path(input int seg, input int src, input int dst,
                                       input int n, input logic cw);
    int hops;
    int ofs;
    if (cw) begin
      hops = cw_hops(src, dst, n);
      ofs  = (seg - src + n) % n;
    end else begin
      hops = cw_hops(dst, src, n);
      ofs  = (src - seg + n) % n;
    end
    return (ofs < hops);
  endfunction

endpackage

// File: rtl/ring_path_calc.sv
module ring_path_calc #(
  parameter int NODES  = 12,
  parameter int NODE_W = 4,
  parameter int SRC    = 0
) (
  input  logic [NODE_W-1:0] dst,
  output logic [NODES-1:0]  mask_cw,
  output logic [NODES-1:0]  mask_ccw,
  output logic              pref_cw,
  output logic              bad_dst
);
  import ring_arb_pkg::*;

  always_comb begin
    int d;
    d        = int'(dst);
    bad_dst  = (d == SRC) || (d >= NODES);
    pref_cw  = prefer_cw(SRC, d, NODES);
    mask_cw  = '0;
    mask_ccw = '0;
    if (!bad_dst) begin
      for (int i = 0; i < NODES; i++) begin
        mask_cw[i]  = seg_on_path(i, SRC, d, NODES, 1'b1);
        mask_ccw[i] = seg_on_path(i, SRC, d, NODES, 1'b0);
      end
    end
  end
endmodule

// File: rtl/ring_slot_tracker.sv
module ring_slot_tracker #(
  parameter int NODES    = 12,
  parameter int MAX_XFER = 3,
  parameter int BEATS    = 8,
  parameter int ACT_W    = $clog2(MAX_XFER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [NODES-1:0] alloc_mask,
  output logic [NODES-1:0] occ_mask,
  output logic             full,
  output logic [ACT_W-1:0] active
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic [MAX_XFER-1:0] slot_vld;
  logic [MAX_XFER-1:0] take;
  logic [MAX_XFER-1:0] retire;
  logic [NODES-1:0]    slot_mask [MAX_XFER];
  logic [CNT_W-1:0]    slot_beat [MAX_XFER];

  // First free slot receives a new packet.
  always_comb begin
    logic found;
    found = 1'b0;
    take  = '0;
    for (int s = 0; s < MAX_XFER; s++) begin
      if (alloc && !slot_vld[s] && !found) begin
        take[s] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < MAX_XFER; s++) begin : g_slot
    assign retire[s] = slot_vld[s] && (slot_beat[s] == LAST_BEAT);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[s]  <= 1'b0;
        slot_mask[s] <= '0;
        slot_beat[s] <= '0;
      end else if (take[s]) begin
        slot_vld[s]  <= 1'b1;
        slot_mask[s] <= alloc_mask;
        slot_beat[s] <= '0;
      end else if (retire[s]) begin
        slot_vld[s]  <= 1'b0;
        slot_mask[s] <= '0;
        slot_beat[s] <= '0;
      end else if (slot_vld[s]) begin
        slot_beat[s] <= slot_beat[s] + 1'b1;
      end
    end
  end

  always_comb begin
    occ_mask = '0;
    for (int s = 0; s < MAX_XFER; s++) begin
      if (slot_vld[s]) occ_mask = occ_mask | slot_mask[s];
    end
  end

  assign full   = &slot_vld;
  assign active = ACT_W'($countones(slot_vld));
endmodule

// File: rtl/ring_rr_pick.sv
module ring_rr_pick #(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] last,
  output logic             pick_vld,
  output logic [IDX_W-1:0] pick_idx
);
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!pick_vld && cand[(int'(last) + k) % N]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/ring_bus_arbiter.sv
module ring_bus_arbiter #(
  parameter int NODES         = 12,
  parameter int NODE_W        = 4,
  parameter int RINGS_PER_DIR = 2,
  parameter int MAX_XFER      = 3,
  parameter int BEATS         = 8,
  localparam int RINGS        = 2 * RINGS_PER_DIR,
  localparam int RING_W       = $clog2(RINGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NODES-1:0]        req_vld,
  input  logic [NODES*NODE_W-1:0] req_dst,
  output logic                    gnt_vld,
  output logic [NODE_W-1:0]       gnt_src,
  output logic [RING_W-1:0]       gnt_ring,
  output logic                    err_vld,
  output logic [NODE_W-1:0]       err_src
);
  localparam int ACT_W = $clog2(MAX_XFER + 1);

  logic [NODES-1:0] m_cw  [NODES];
  logic [NODES-1:0] m_ccw [NODES];
  logic [NODES-1:0] pref_cw;
  logic [NODES-1:0] bad_dst;

  logic [NODES-1:0] occ    [RINGS];
  logic [RINGS-1:0] full;
  logic [ACT_W-1:0] active [RINGS];

  logic [RINGS-1:0]  fit      [NODES];
  logic [NODES-1:0]  place_ok;
  logic [RING_W-1:0] pick_ring [NODES];
  logic [NODES-1:0]  cand;

  logic              srv_vld;
  logic [NODE_W-1:0] srv_idx;
  logic [NODE_W-1:0] last_srv;

  // Named wires for the checker.
  logic [RINGS-1:0]       alloc_vec;
  logic [RINGS*NODES-1:0] amask_flat;
  logic [RINGS*NODES-1:0] occ_flat;
  logic [RINGS*ACT_W-1:0] act_flat;

  // Per-node path and direction.
  for (genvar n = 0; n < NODES; n++) begin : g_node
    ring_path_calc #(
      .NODES (NODES),
      .NODE_W(NODE_W),
      .SRC   (n)
    ) u_path (
      .dst     (req_dst[n*NODE_W +: NODE_W]),
      .mask_cw (m_cw[n]),
      .mask_ccw(m_ccw[n]),
      .pref_cw (pref_cw[n]),
      .bad_dst (bad_dst[n])
    );
  end

  // Which rings could take each node's transfer right now.
  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      for (int r = 0; r < RINGS; r++) begin
        fit[n][r] = !full[r] &&
                    ((occ[r] & ((r < RINGS_PER_DIR) ? m_cw[n] : m_ccw[n])) == '0);
      end
    end
  end

  // Preferred direction first, lower ring first, then the other direction.
  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      place_ok[n]  = 1'b0;
      pick_ring[n] = '0;
      for (int p = 0; p < 2; p++) begin
        for (int q = 0; q < RINGS_PER_DIR; q++) begin
          if (!place_ok[n] && !bad_dst[n]) begin
            if (((p == 0) == pref_cw[n]) ? fit[n][q] : fit[n][RINGS_PER_DIR + q]) begin
              place_ok[n]  = 1'b1;
              pick_ring[n] = ((p == 0) == pref_cw[n]) ? RING_W'(q)
                                                      : RING_W'(RINGS_PER_DIR + q);
            end
          end
        end
      end
    end
  end

  assign cand = req_vld & (bad_dst | place_ok);

  ring_rr_pick #(
    .N    (NODES),
    .IDX_W(NODE_W)
  ) u_rr (
    .cand    (cand),
    .last    (last_srv),
    .pick_vld(srv_vld),
    .pick_idx(srv_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       last_srv <= NODE_W'(NODES - 1);
    else if (srv_vld) last_srv <= srv_idx;
  end

  assign gnt_vld  = srv_vld && !bad_dst[srv_idx];
  assign err_vld  = srv_vld &&  bad_dst[srv_idx];
  assign gnt_src  = srv_idx;
  assign err_src  = srv_idx;
  assign gnt_ring = pick_ring[srv_idx];

  for (genvar r = 0; r < RINGS; r++) begin : g_ring
    assign alloc_vec[r] = gnt_vld && (gnt_ring == RING_W'(r));
    if (r < RINGS_PER_DIR) begin : g_cw
      assign amask_flat[r*NODES +: NODES] = m_cw[srv_idx];
    end else begin : g_ccw
      assign amask_flat[r*NODES +: NODES] = m_ccw[srv_idx];
    end

    ring_slot_tracker #(
      .NODES   (NODES),
      .MAX_XFER(MAX_XFER),
      .BEATS   (BEATS),
      .ACT_W   (ACT_W)
    ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc_vec[r]),
      .alloc_mask(amask_flat[r*NODES +: NODES]),
      .occ_mask  (occ[r]),
      .full      (full[r]),
      .active    (active[r])
    );

    assign occ_flat[r*NODES +: NODES] = occ[r];
    assign act_flat[r*ACT_W +: ACT_W] = active[r];
  end
endmodule

// File: rtl/ring_bus_arbiter_chk.sv
module ring_bus_arbiter_chk #(
  parameter int NODES    = 12,
  parameter int NODE_W   = 4,
  parameter int RINGS    = 4,
  parameter int MAX_XFER = 3,
  parameter int ACT_W    = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NODES-1:0]        req_vld,
  input logic [NODES*NODE_W-1:0] req_dst,
  input logic                    gnt_vld,
  input logic [NODE_W-1:0]       gnt_src,
  input logic                    err_vld,
  input logic [NODE_W-1:0]       err_src,
  input logic [RINGS-1:0]        alloc_vec,
  input logic [RINGS*NODES-1:0]  amask_flat,
  input logic [RINGS*NODES-1:0]  occ_flat,
  input logic [RINGS*ACT_W-1:0]  act_flat
);

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_vld && err_vld));

  a_r8_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req_vld[gnt_src]);

  a_r8_error_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> req_vld[err_src]);

  a_r8_one_ring_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  a_r2_error_only_bad: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> ((req_dst[err_src*NODE_W +: NODE_W] == err_src) ||
                 (int'(req_dst[err_src*NODE_W +: NODE_W]) >= NODES)));

  a_r2_no_grant_bad: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ((req_dst[gnt_src*NODE_W +: NODE_W] != gnt_src) &&
                 (int'(req_dst[gnt_src*NODE_W +: NODE_W]) < NODES)));

  for (genvar r = 0; r < RINGS; r++) begin : g_ring_chk
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vec[r] |-> ((occ_flat[r*NODES +: NODES] & amask_flat[r*NODES +: NODES]) == '0));

    a_r6_limit: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vec[r] |-> (int'(act_flat[r*ACT_W +: ACT_W]) < MAX_XFER));

    a_r7_reserved_next: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vec[r] |=> ((occ_flat[r*NODES +: NODES] & $past(amask_flat[r*NODES +: NODES]))
                        == $past(amask_flat[r*NODES +: NODES])));
  end
endmodule

bind ring_bus_arbiter ring_bus_arbiter_chk #(
  .NODES   (NODES),
  .NODE_W  (NODE_W),
  .RINGS   (RINGS),
  .MAX_XFER(MAX_XFER),
  .ACT_W   (ACT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_dst   (req_dst),
  .gnt_vld   (gnt_vld),
  .gnt_src   (gnt_src),
  .err_vld   (err_vld),
  .err_src   (err_src),
  .alloc_vec (alloc_vec),
  .amask_flat(amask_flat),
  .occ_flat  (occ_flat),
  .act_flat  (act_flat)
);

// File: tb/test_ring_bus_arbiter.sv
`timescale 1ns/1ps
module test_ring_bus_arbiter;
  localparam int NODES = 12;
  localparam int NW    = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NODES-1:0]  req_vld = '0;
  logic [NODES*NW-1:0] req_dst = '0;
  logic              gnt_vld;
  logic [NW-1:0]     gnt_src;
  logic [1:0]        gnt_ring;
  logic              err_vld;
  logic [NW-1:0]     err_src;

  int applied = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  ring_bus_arbiter i_ring_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dst(req_dst),
    .gnt_vld(gnt_vld), .gnt_src(gnt_src), .gnt_ring(gnt_ring),
    .err_vld(err_vld), .err_src(err_src)
  );

  // kind: 0 none, 1 grant, 2 error. Fields {req, src, dst, kind, ring}.
  localparam logic [12:0] VEC [14] = '{
    {1'b1, 4'd0,  4'd3,  2'd1, 2'd0},  // R3 short CW, ring 0
    {1'b1, 4'd2,  4'd5,  2'd1, 2'd1},  // R5 overlap seg2 -> ring 1
    {1'b1, 4'd1,  4'd2,  2'd1, 2'd1},  // R5 seg1 busy on ring 0
    {1'b1, 4'd5,  4'd5,  2'd2, 2'd0},  // R2 self
    {1'b1, 4'd6,  4'd9,  2'd1, 2'd0},  // R3
    {1'b1, 4'd0,  4'd1,  2'd1, 2'd1},  // R5 ring 1 third
    {1'b1, 4'd10, 4'd11, 2'd1, 2'd0},  // R6 ring 0 third
    {1'b1, 4'd11, 4'd0,  2'd1, 2'd2},  // R4 both CW full -> CCW
    {1'b1, 4'd4,  4'd3,  2'd1, 2'd3},  // R3 CCW preferred, ring 2 blocked
    {1'b1, 4'd3,  4'd4,  2'd1, 2'd0},  // R7 vector 0 freed this cycle
    {1'b1, 4'd7,  4'd6,  2'd1, 2'd3},  // R5 ring 2 blocked
    {1'b1, 4'd6,  4'd7,  2'd1, 2'd1},  // R7 ring 1 freed
    {1'b1, 4'd4,  4'd13, 2'd2, 2'd0},  // R2 out of range
    {1'b0, 4'd0,  4'd0,  2'd0, 2'd0}   // R8 idle
  };

  task automatic set_req(input int n, input int d);
    req_vld[n] = 1'b1;
    req_dst[n*NW +: NW] = NW'(d);
  endtask

  task automatic clr_req(input int n);
    req_vld[n] = 1'b0;
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  // kind: 0 none, 1 grant, 2 error
  task automatic expect_out(input string tag, input int kind, input int src, input int ring);
    logic bad;
    @(negedge clk);
    applied++;
    bad = 1'b0;
    if (kind == 1) bad = !gnt_vld || err_vld || (int'(gnt_src) != src) || (int'(gnt_ring) != ring);
    else if (kind == 2) bad = gnt_vld || !err_vld || (int'(err_src) != src);
    else bad = gnt_vld || err_vld;
    if (bad) begin
      miscompares++;
      $display("FAIL %s: got gnt=%0d src=%0d ring=%0d err=%0d esrc=%0d, expected kind=%0d src=%0d ring=%0d",
               tag, gnt_vld, gnt_src, gnt_ring, err_vld, err_src, kind, src, ring);
    end
  endtask

  task automatic do_reset();
    req_vld = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    // R1 reset state: no outcome with no request
    do_reset();
    expect_out("R1 idle after reset", 0, 0, 0);

    // Vector table
    do_reset();
    for (int k = 0; k < 14; k++) begin
      next_cycle();
      req_vld = '0;
      if (VEC[k][12]) set_req(int'(VEC[k][11:8]), int'(VEC[k][7:4]));
      expect_out($sformatf("table vector %0d", k), int'(VEC[k][3:2]),
                 int'(VEC[k][11:8]), int'(VEC[k][1:0]));
    end
    next_cycle();
    req_vld = '0;

    // R1 / R8 round robin order
    do_reset();
    set_req(3, 4); set_req(11, 0);
    expect_out("R1 node 3 first after reset", 1, 3, 0);
    next_cycle(); clr_req(3);
    expect_out("R8 node 11 next", 1, 11, 0);
    next_cycle(); clr_req(11); set_req(5, 6); set_req(9, 10);
    expect_out("R8 wrap to node 5", 1, 5, 0);
    next_cycle(); clr_req(5);
    expect_out("R6 ring 0 full, node 9 on ring 1", 1, 9, 1);
    next_cycle(); clr_req(9); set_req(1, 2); set_req(10, 11);
    expect_out("R8 node 10 after 9", 1, 10, 1);
    next_cycle(); clr_req(10);
    expect_out("R8 node 1 wraps", 1, 1, 1);
    next_cycle(); clr_req(1); set_req(7, 8);
    expect_out("R4 fallback to CCW", 1, 7, 2);
    next_cycle(); clr_req(7); set_req(0, 0); set_req(4, 5);
    expect_out("R2 error takes slot", 2, 0, 0);
    next_cycle(); clr_req(0);
    expect_out("R4 node 4 on ring 3", 1, 4, 3);
    next_cycle(); clr_req(4);

    // R3 tie, R9 blocked skip, R7 release timing
    do_reset();
    set_req(0, 6);
    expect_out("R3 tie goes CW ring 0", 1, 0, 0);
    next_cycle();
    expect_out("R5 ring 1", 1, 0, 1);
    next_cycle();
    expect_out("R4 ring 2", 1, 0, 2);
    next_cycle();
    expect_out("R4 ring 3", 1, 0, 3);
    next_cycle();
    expect_out("R9 all blocked", 0, 0, 0);
    next_cycle(); set_req(3, 2);
    expect_out("R9 skip blocked node 0", 1, 3, 2);
    next_cycle(); clr_req(3);
    expect_out("R7 still held c+6", 0, 0, 0);
    next_cycle();
    expect_out("R7 still held c+7", 0, 0, 0);
    next_cycle();
    expect_out("R7 still held c+8", 0, 0, 0);
    next_cycle();
    expect_out("R7 released c+9", 1, 0, 0);
    next_cycle(); clr_req(0);
    expect_out("R8 idle", 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule